// File: doc/BRIEF.md
# Same-Address Burst Write Port into a Queue

This block is a write-only AXI4 subordinate that stands in front of one hardware queue living at a single address. A manager such as a DMA engine sends a FIXED burst (burst type 2'b00): one address transaction followed by AWLEN+1 data beats, all aimed at the same location. The block turns each data beat into one queue entry. An entry holds the full data word and a byte-enable mask. The mask is the beat's own WSTRB, restricted to the lanes that the address and size select. After the final beat the block returns one write response.

Requests that the queue cannot honour still complete on the bus, so the manager never hangs. These are bursts of another type, FIXED bursts longer than 16 beats, beats wider than the data bus, and bursts whose WLAST falls on the wrong beat. Their beats are absorbed and the response is SLVERR. Since the address never moves, no 4 KB boundary check is made.

Data flows through valid/ready pairs at both ends. On the bus side, WREADY drops while the queue is full, so the manager is held rather than losing a beat. On the consumer side, an entry is offered on `q_valid` and leaves on the cycle `q_valid` and `q_ready` are both high. It stays unchanged while `q_ready` is low. Only one transaction is open at a time: AWREADY stays low from address acceptance until the response handshake.

Top module: `fixed_fifo_wr_port`

## Requirements
- R1: After reset, awready is 1, wready is 0, bvalid is 0 and q_valid is 0.
- R2: A legal burst is one with AWBURST = 2'b00, AWLEN <= 15 and 2^AWSIZE no larger than the bus width in bytes. It pushes exactly AWLEN+1 entries, one per W handshake and in beat order, each carrying WDATA unchanged.
- R3: The stored mask is WSTRB AND a lane mask. Lane i is in the lane mask when floor(i/2^AWSIZE) equals floor(a/2^AWSIZE) and i >= a, where a is the address modulo the bus width in bytes. The lane mask is the same on every beat.
- R4: Strobes are taken per beat, so successive entries of one burst may carry different masks.
- R5: Exactly one response follows each accepted address, and only after the beat carrying WLAST. BID equals the AWID of that address. BRESP is 2'b00 (OKAY) when the burst is legal and WLAST came on beat AWLEN. BID and BRESP hold while bvalid waits for bready.
- R6: A burst with AWBURST of 2'b01, 2'b10 or 2'b11 has all its beats accepted without any push, and it receives BRESP 2'b10 (SLVERR).
- R7: A FIXED burst with AWLEN > 15, or with 2^AWSIZE above the bus width in bytes, has its beats accepted without any push and receives SLVERR.
- R8: If WLAST comes before beat AWLEN, the beats up to and including it are pushed and the response is SLVERR. If WLAST is missing on beat AWLEN, further beats are accepted without pushing until WLAST arrives, and the response is SLVERR.
- R9: During a pushing burst, wready is 0 while the queue is full, and no push occurs when the queue is full. awready is 0 from address acceptance until the response handshake.
- R10: While q_valid is 1 and q_ready is 0, q_valid stays 1 and q_data and q_strb stay unchanged.
- R11: A burst that follows an errored burst is handled exactly as if no error had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| awid | input | ID_W | Write address ID |
| awaddr | input | ADDR_W | Write address |
| awlen | input | 8 | Beats minus one |
| awsize | input | 3 | log2 of bytes per beat |
| awburst | input | 2 | Burst type |
| awvalid | input | 1 | Address valid |
| awready | output | 1 | Address ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write strobes |
| wlast | input | 1 | Final beat marker |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bid | output | ID_W | Response ID |
| bresp | output | 2 | Response code |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response ready |
| q_data | output | DATA_W | Queue head data |
| q_strb | output | DATA_W/8 | Queue head byte mask |
| q_valid | output | 1 | Queue head present |
| q_ready | input | 1 | Consumer takes head |

## Verification
Legal bursts are tried at full width, one byte, an aligned halfword and an unaligned halfword. These separate a correct lane restriction from a plain copy of WSTRB. A strobe pattern that rotates per beat shows that masks are not latched from beat zero. Type errors, length errors, oversized beats, and early and late WLAST each show whether beats are dropped or kept and which response code comes back. A legal burst after them shows recovery. A held consumer with a 16-beat burst checks that the queue stalls without loss and without reordering.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam int unsigned MAX_FIXED_LEN = 15;

  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_DATA = 2'd1,
    ST_RESP = 2'd2
  } port_state_e;
endpackage

// File: rtl/fwp_lane_mask.sv
module fwp_lane_mask #(
  parameter int STRB_W = 4,
  localparam int LANE_W = $clog2(STRB_W)
) (
  input  logic [LANE_W-1:0] addr_lo,
  input  logic [2:0]        size,
  output logic [STRB_W-1:0] mask
);
  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    localparam int LANE = i;
    logic [31:0] lane_blk, addr_blk;
    assign lane_blk = 32'(LANE) >> size;
    assign addr_blk = 32'(addr_lo) >> size;
    assign mask[i]  = (lane_blk == addr_blk) && (32'(LANE) >= 32'(addr_lo));
  end
endmodule

// File: rtl/fwp_queue.sv
module fwp_queue #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign in_ready  = (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: nothing enters a full queue
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)) || $past(pop));

  // R10: head holds under back-pressure
  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/fixed_fifo_wr_port.sv
module fixed_fifo_wr_port
  import fwp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 8,
  localparam int STRB_W   = DATA_W / 8,
  localparam int LANE_W   = $clog2(STRB_W),
  localparam int MAX_SIZE = LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wlast,
  input  logic              wvalid,
  output logic              wready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic [DATA_W-1:0] q_data,
  output logic [STRB_W-1:0] q_strb,
  output logic              q_valid,
  input  logic              q_ready
);
  port_state_e       st;
  logic [ID_W-1:0]   id_q;
  logic [7:0]        len_q, cnt_q;
  logic [STRB_W-1:0] lane_d, lane_q;
  logic              hdr_err_d, hdr_err_q, prot_err_q, over_q;
  logic              aw_fire, w_fire, b_fire, drop;
  logic              push_valid, push_ready;
  logic [STRB_W+DATA_W-1:0] push_word, head_word;

  fwp_lane_mask #(.STRB_W(STRB_W)) u_lanes (
    .addr_lo (awaddr[LANE_W-1:0]),
    .size    (awsize),
    .mask    (lane_d)
  );

  assign hdr_err_d = (awburst != BURST_FIXED) ||
                     (awlen > 8'(MAX_FIXED_LEN)) ||
                     (awsize > 3'(MAX_SIZE));

  assign awready = (st == ST_ADDR);
  assign bvalid  = (st == ST_RESP);
  assign bid     = id_q;
  assign bresp   = (hdr_err_q || prot_err_q) ? RESP_SLVERR : RESP_OKAY;

  assign drop       = hdr_err_q || over_q;
  assign wready     = (st == ST_DATA) && (drop || push_ready);
  assign push_valid = (st == ST_DATA) && wvalid && !drop;
  assign push_word  = {wstrb & lane_q, wdata};

  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign b_fire  = bvalid && bready;

  fwp_queue #(.W(STRB_W + DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (push_word),
    .in_valid  (push_valid),
    .in_ready  (push_ready),
    .out_data  (head_word),
    .out_valid (q_valid),
    .out_ready (q_ready)
  );

  assign q_data = head_word[DATA_W-1:0];
  assign q_strb = head_word[STRB_W+DATA_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_ADDR;
      id_q       <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      lane_q     <= '0;
      hdr_err_q  <= 1'b0;
      prot_err_q <= 1'b0;
      over_q     <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (aw_fire) begin
          st         <= ST_DATA;
          id_q       <= awid;
          len_q      <= awlen;
          lane_q     <= lane_d;
          hdr_err_q  <= hdr_err_d;
          prot_err_q <= 1'b0;
          over_q     <= 1'b0;
          cnt_q      <= '0;
        end
        ST_DATA: if (w_fire) begin
          if (wlast) begin
            st <= ST_RESP;
            if (cnt_q != len_q || over_q) prot_err_q <= 1'b1;
          end else if (!drop) begin
            if (cnt_q == len_q) begin
              over_q     <= 1'b1;
              prot_err_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RESP: if (b_fire) st <= ST_ADDR;
        default: st <= ST_ADDR;
      endcase
    end
  end

  // R9: one transaction open at a time
  assert_aw_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |=> !awready);

  // R5: response fields hold until taken
  assert_resp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

  // R5: no data accepted while a response is pending
  assert_no_beat_in_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !wready);

  // R9: full queue stalls a pushing burst
  assert_stall_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |-> !wready);
endmodule

// File: tb/fixed_fifo_wr_port_bench.sv
module fixed_fifo_wr_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int STRB_W = 4;
  localparam int ID_W   = 4;
  localparam int NVEC   = 11;

  // stimulus table: burst, len, size, addr low bits, beats sent (WLAST on the last)
  localparam int V_BURST [NVEC] = '{0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0};
  localparam int V_LEN   [NVEC] = '{3, 0, 15, 2, 1, 3, 16, 3, 1, 0, 1};
  localparam int V_SIZE  [NVEC] = '{2, 0, 1, 1, 2, 2, 2, 2, 2, 3, 2};
  localparam int V_ADDR  [NVEC] = '{0, 3, 2, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_BEATS [NVEC] = '{4, 1, 16, 3, 2, 4, 17, 2, 4, 1, 2};

  logic clk = 0, rst_n = 0;
  logic [ID_W-1:0] awid = '0;
  logic [15:0] awaddr = '0;
  logic [7:0] awlen = '0;
  logic [2:0] awsize = '0;
  logic [1:0] awburst = '0;
  logic awvalid = 0, awready;
  logic [DATA_W-1:0] wdata = '0;
  logic [STRB_W-1:0] wstrb = '0;
  logic wlast = 0, wvalid = 0, wready;
  logic [ID_W-1:0] bid;
  logic [1:0] bresp;
  logic bvalid, bready = 0;
  logic [DATA_W-1:0] q_data;
  logic [STRB_W-1:0] q_strb;
  logic q_valid, q_ready = 1;

  int n_tests = 0, n_fail = 0;
  logic [DATA_W-1:0] exp_data [256];
  logic [STRB_W-1:0] exp_strb [256];
  int wr_i = 0, rd_i = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_fifo_wr_port u_fixed_fifo_wr_port (
    .clk(clk), .rst_n(rst_n),
    .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awburst(awburst), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .q_data(q_data), .q_strb(q_strb), .q_valid(q_valid), .q_ready(q_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [STRB_W-1:0] lanes(input int size, input int a);
    logic [STRB_W-1:0] m;
    for (int i = 0; i < STRB_W; i++) m[i] = ((i >> size) == (a >> size)) && (i >= a);
    return m;
  endfunction

  function automatic logic [STRB_W-1:0] strb_pat(input int b);
    case (b % 4)
      0: return 4'hF;
      1: return 4'h5;
      2: return 4'hA;
      default: return 4'h3;
    endcase
  endfunction

  // consumer: compares each popped entry with the expected order (R2, R3, R4)
  always @(negedge clk) begin
    if (rst_n && q_valid && q_ready) begin
      if (rd_i >= wr_i) begin
        check(0, "R2/R6", "unexpected push", q_data, 0);
      end else begin
        check(q_data == exp_data[rd_i], "R2", "entry data", q_data, exp_data[rd_i]);
        check(q_strb == exp_strb[rd_i], "R3/R4", "entry mask", q_strb, exp_strb[rd_i]);
      end
      rd_i++;
    end
  end

  task automatic run_burst(input int burst, input int len, input int size, input int a,
                           input int nbeats, input int id, input logic [31:0] seed);
    bit legal;
    logic [1:0] exp_resp;
    legal = (burst == 0) && (len <= 15) && (size <= 2);
    exp_resp = (legal && nbeats == len + 1) ? 2'b00 : 2'b10;
    @(negedge clk);
    awid = ID_W'(id); awaddr = 16'h4000 | 16'(a); awlen = 8'(len);
    awsize = 3'(size); awburst = 2'(burst); awvalid = 1;
    while (!awready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    awvalid = 0;
    for (int b = 0; b < nbeats; b++) begin
      wdata = seed + 32'(b) * 32'h0101_0101; wstrb = strb_pat(b);
      wlast = (b == nbeats - 1); wvalid = 1;
      while (!wready) @(negedge clk);
      @(posedge clk);
      if (legal && b <= len) begin
        exp_data[wr_i] = wdata;
        exp_strb[wr_i] = wstrb & lanes(size, a);
        wr_i++;
      end
      @(negedge clk);
      wvalid = 0; wlast = 0;
    end
    bready = 1;
    while (!bvalid) @(negedge clk);
    check(bresp == exp_resp, "R5/R6/R7/R8", "bresp", bresp, exp_resp);
    check(bid == ID_W'(id), "R5", "bid", bid, id);
    @(posedge clk);
    @(negedge clk);
    bready = 0;
    check(bvalid == 0, "R5", "single response", bvalid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(awready == 1, "R1", "awready", awready, 1);
    check(wready == 0, "R1", "wready", wready, 0);
    check(bvalid == 0, "R1", "bvalid", bvalid, 0);
    check(q_valid == 0, "R1", "q_valid", q_valid, 0);
    rst_n = 1;

    // table walk: legal lane cases, R6/R7 errors, R8 early and late WLAST, R11 recovery
    for (int v = 0; v < NVEC; v++) begin
      run_burst(V_BURST[v], V_LEN[v], V_SIZE[v], V_ADDR[v], V_BEATS[v], v,
                32'h1000_0000 * 32'(v + 1));
      repeat (4) @(negedge clk);
      check(rd_i == wr_i, "R2/R8", "entries drained", rd_i, wr_i);
      check(q_valid == 0, "R6/R7", "no stray entry", q_valid, 0);
    end

    // reserved burst type 11 (R6)
    run_burst(3, 1, 2, 0, 2, 5, 32'hDEAD_0000);
    repeat (4) @(negedge clk);
    check(rd_i == wr_i, "R6", "reserved type pushes", rd_i, wr_i);

    // R9/R10: consumer stalled, 16-beat burst into an 8-deep queue
    q_ready = 0;
    fork
      run_burst(0, 15, 2, 0, 16, 9, 32'hC0DE_0000);
      begin
        repeat (30) @(negedge clk);
        check(wready == 0, "R9", "wready while full", wready, 0);
        check(awready == 0, "R9", "awready mid-burst", awready, 0);
        held = q_data;
        repeat (5) @(negedge clk);
        check(q_valid == 1, "R10", "head kept valid", q_valid, 1);
        check(q_data == held, "R10", "head stable", q_data, held);
        q_ready = 1;
      end
    join
    repeat (20) @(negedge clk);
    check(rd_i == wr_i, "R9", "no beat lost under stall", rd_i, wr_i);
    check(rd_i > 0, "R2", "entries seen", rd_i, 1);

    // R11: legal burst after errors, alternate strobe phase
    run_burst(0, 2, 2, 0, 3, 12, 32'h7700_0000);
    repeat (8) @(negedge clk);
    check(rd_i == wr_i, "R11", "recovery pushes", rd_i, wr_i);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule